// File: doc/BRIEF.md
# Converter Data-Ready Serial Output Controller

This block drives the single output pin of a converter's serial port. That pin carries both the result bits and a data-ready flag. When a conversion finishes, the converter presents its result word on a valid/ready input. The controller captures the word and pulls the pin low to show that new data is waiting. This works even when the host keeps chip select low all the time. The host then clocks the word out, MSB first, on rising serial-clock edges. After the last bit the pin sits high until the next result arrives.

In continuous mode a result may never be read. In that case the controller withdraws the flag, so the pin goes high, a fixed lead time before the next result is due. The lead time is set in nanoseconds and converted to system-clock cycles. The next result time comes from a programmable conversion-period count. If a read is still running at that moment, a one-cycle late-read flag is raised. While chip select is high the pin is not driven, and a weak pull-up is turned on unless a configuration bit turns it off.

The result stream has no back-pressure on the producer. `res_ready` is high whenever no read is in progress. A beat offered while `res_ready` is low is discarded, and nothing changes. The serial clock and chip select are taken to be already synchronous to `clk`.

Top module: `drdy_dout_ctrl`

## Requirements
- R1: While synchronous reset `rst` is high, and on the cycle after it, `dout_oe`=0, `dout_pu`=1, `res_ready`=1, `late_read`=0 and `dout`=1.
- R2: A beat with `res_valid`=1 and `res_ready`=1 captures `res_data`. `dout` is 0 from the next cycle.
- R3: While `res_ready` is 0 (a read is in progress), a `res_valid` beat is dropped. It sets no flag and changes no stored word.
- R4: With `cs_n`=0 and the flag set, the first rising `sclk` (sampled high one cycle after being sampled low) puts bit 15 on `dout` in the next cycle. Each later rise puts the next lower bit there, until all 16 bits have been sent.
- R5: The rising `sclk` after the 16th bit ends the read. `dout` then goes to 1 and `res_ready` to 1.
- R6: The flag clears when the first bit is shifted. After a completed read, `dout` stays 1 until a new result is captured.
- R7: `cs_n`=1 during a read aborts it. `res_ready` returns to 1 in the next cycle and the flag stays clear.
- R8: With `cont_mode`=1 and the result unread, `dout` goes to 1 exactly `conv_period` − LEAD cycles after the capturing edge. LEAD is `LEAD_NS`/`CLK_NS` (800 by default) and `conv_period` must exceed it.
- R9: With `cont_mode`=0 an unread flag is kept indefinitely.
- R10: If a read is still in progress at the R8 drop point in continuous mode, `late_read` is 1 for exactly one cycle.
- R11: `dout_oe` equals the inverse of `cs_n` one cycle earlier. `dout_pu` equals `cs_n` AND `cfg_pullup` one cycle earlier.
- R12: A rising `sclk` with `cs_n`=1, or with the flag clear, is ignored. `dout` and `res_ready` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cont_mode | input | 1 | 1 = continuous conversions, 0 = single shot |
| conv_period | input | 16 | Cycles between conversion results |
| cfg_pullup | input | 1 | Weak pull-up enable while deselected |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| res_valid | input | 1 | Result word offered |
| res_ready | output | 1 | High when a result can be captured |
| res_data | input | 16 | Result word |
| dout | output | 1 | Pin value: data bit or inverted ready flag |
| dout_oe | output | 1 | Pin output enable |
| dout_pu | output | 1 | Weak pull-up enable |
| late_read | output | 1 | One-cycle pulse: read overran the drop point |

## Verification
The assertions take three things for granted about the inputs. `sclk` and `cs_n` are already synchronous to `clk`. `conv_period` is larger than the lead count and stays stable while a result is pending. A result beat never lands in the same cycle as a serial-clock rise that would start a read. The stimulus changes inputs only just after a clock edge, and it holds `sclk` high and low for several cycles per bit. It keeps `conv_period` at 1200 throughout, and it spaces result beats well away from read starts. That keeps every scenario within these limits.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
  typedef enum logic {
    SH_IDLE  = 1'b0,
    SH_SHIFT = 1'b1
  } shift_state_e;
endpackage

// File: rtl/dr_edge_detect.sv
module dr_edge_detect #(
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= RST_LEVEL;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/dr_lead_timer.sv
module dr_lead_timer #(
  parameter int PERIOD_W = 16,
  parameter int LEAD_CYC = 800
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                cont_mode,
  input  logic [PERIOD_W-1:0] period,
  output logic                warn
);
  localparam logic [PERIOD_W-1:0] LEAD_V = PERIOD_W'(LEAD_CYC);
  localparam logic [PERIOD_W-1:0] SAT_V  = '1;

  logic [PERIOD_W-1:0] elapsed_q;
  logic [PERIOD_W-1:0] drop_at;

  // the flag drops LEAD cycles ahead of the next expected result
  assign drop_at = period - LEAD_V - PERIOD_W'(1);
  assign warn    = cont_mode && (period > LEAD_V) && (elapsed_q == drop_at);

  always_ff @(posedge clk) begin
    if (rst)                    elapsed_q <= SAT_V;
    else if (restart)           elapsed_q <= '0;
    else if (elapsed_q != SAT_V) elapsed_q <= elapsed_q + PERIOD_W'(1);
  end
endmodule

// File: rtl/dr_shifter.sv
module dr_shifter
  import drdy_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              sclk_rise,
  input  logic              cs_n,
  input  logic              warn,
  output logic              accept,
  output logic              busy,
  output logic              pin_val
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  shift_state_e      state_q;
  logic [DATA_W-1:0] word_q;
  logic [CNT_W-1:0]  sent_q;
  logic              bit_q;
  logic              flag_q;

  assign busy    = (state_q == SH_SHIFT);
  assign accept  = in_valid && !busy;
  assign pin_val = busy ? bit_q : ~flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SH_IDLE;
      word_q  <= '0;
      sent_q  <= '0;
      bit_q   <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SH_IDLE: begin
          if (accept) begin
            word_q <= in_data;
            flag_q <= 1'b1;
          end else if (sclk_rise && !cs_n && flag_q) begin
            bit_q   <= word_q[DATA_W-1];
            word_q  <= {word_q[DATA_W-2:0], 1'b0};
            sent_q  <= CNT_W'(1);
            flag_q  <= 1'b0;
            state_q <= SH_SHIFT;
          end else if (warn) begin
            flag_q <= 1'b0;
          end
        end
        SH_SHIFT: begin
          if (cs_n) begin
            sent_q  <= '0;
            state_q <= SH_IDLE;
          end else if (sclk_rise) begin
            if (sent_q == LAST) begin
              sent_q  <= '0;
              state_q <= SH_IDLE;
            end else begin
              bit_q  <= word_q[DATA_W-1];
              word_q <= {word_q[DATA_W-2:0], 1'b0};
              sent_q <= sent_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/drdy_dout_ctrl.sv
module drdy_dout_ctrl #(
  parameter int DATA_W   = 16,
  parameter int PERIOD_W = 16,
  parameter int CLK_NS   = 10,
  parameter int LEAD_NS  = 8000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cont_mode,
  input  logic [PERIOD_W-1:0] conv_period,
  input  logic                cfg_pullup,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                res_valid,
  output logic                res_ready,
  input  logic [DATA_W-1:0]   res_data,
  output logic                dout,
  output logic                dout_oe,
  output logic                dout_pu,
  output logic                late_read
);
  localparam int LEAD_CYC = LEAD_NS / CLK_NS;

  logic sclk_rise;
  logic warn;
  logic accept;
  logic busy;
  logic oe_q, pu_q, late_q;

  dr_edge_detect #(.RST_LEVEL(1'b1)) u_edge (
    .clk(clk), .rst(rst), .level(sclk), .rise(sclk_rise)
  );

  dr_lead_timer #(.PERIOD_W(PERIOD_W), .LEAD_CYC(LEAD_CYC)) u_timer (
    .clk(clk), .rst(rst), .restart(accept), .cont_mode(cont_mode),
    .period(conv_period), .warn(warn)
  );

  dr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .in_valid(res_valid), .in_data(res_data),
    .sclk_rise(sclk_rise), .cs_n(cs_n), .warn(warn),
    .accept(accept), .busy(busy), .pin_val(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      pu_q   <= 1'b1;
      late_q <= 1'b0;
    end else begin
      oe_q   <= ~cs_n;
      pu_q   <= cs_n & cfg_pullup;
      late_q <= warn & busy;
    end
  end

  assign res_ready = ~busy;
  assign dout_oe   = oe_q;
  assign dout_pu   = pu_q;
  assign late_read = late_q;
endmodule

// File: rtl/drdy_dout_chk.sv
module drdy_dout_chk (
  input logic clk,
  input logic rst,
  input logic cont_mode,
  input logic cfg_pullup,
  input logic cs_n,
  input logic sclk,
  input logic res_valid,
  input logic res_ready,
  input logic dout,
  input logic dout_oe,
  input logic dout_pu,
  input logic late_read
);
  assert_oe_follows_cs_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dout_oe == !$past(cs_n)));

  assert_pullup_follows_cfg_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dout_pu == ($past(cs_n) && $past(cfg_pullup))));

  assert_capture_flags_low_R2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready) |=> !dout);

  assert_read_starts_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(res_ready) |-> ($past(sclk) && !$past(cs_n)));

  assert_deselect_aborts_R7: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !res_ready) |=> res_ready);

  assert_late_only_continuous_R10: assert property (@(posedge clk) disable iff (rst)
    late_read |-> ($past(cont_mode) && !$past(res_ready)));
endmodule

bind drdy_dout_ctrl drdy_dout_chk u_chk (
  .clk(clk), .rst(rst), .cont_mode(cont_mode), .cfg_pullup(cfg_pullup),
  .cs_n(cs_n), .sclk(sclk), .res_valid(res_valid), .res_ready(res_ready),
  .dout(dout), .dout_oe(dout_oe), .dout_pu(dout_pu), .late_read(late_read)
);

// File: tb/drdy_dout_ctrl_tb.sv
module drdy_dout_ctrl_tb;
  localparam int LEAD = 800;
  localparam int PER  = 1200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cont_mode = 1'b0;
  logic [15:0] conv_period = 16'(PER);
  logic        cfg_pullup = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic        res_ready, dout, dout_oe, dout_pu, late_read;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit seen_late = 1'b0;

  always #5 clk = ~clk;

  drdy_dout_ctrl u_dut (
    .clk(clk), .rst(rst), .cont_mode(cont_mode), .conv_period(conv_period),
    .cfg_pullup(cfg_pullup), .cs_n(cs_n), .sclk(sclk), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .dout(dout), .dout_oe(dout_oe),
    .dout_pu(dout_pu), .late_read(late_read)
  );

  // behavioural reference model
  int  m_word, m_bits, m_elapsed;
  bit  m_flag, m_shift, m_bit, m_oe, m_pu, m_late, m_prev;
  bit  m_rise, m_warn, m_acc, m_start;
  bit  m_live = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_flag = 0; m_shift = 0; m_bits = 0; m_bit = 1; m_elapsed = 65535;
      m_oe = 0; m_pu = 1; m_late = 0; m_prev = 1; m_word = 0; m_live = 1;
    end else begin
      m_rise  = sclk && !m_prev;
      m_warn  = cont_mode && (int'(conv_period) > LEAD) &&
                (m_elapsed == int'(conv_period) - LEAD - 1);
      m_acc   = res_valid && !m_shift;
      m_start = !m_shift && !m_acc && m_rise && !cs_n && m_flag;
      m_late  = m_warn && m_shift;
      if (m_shift) begin
        if (cs_n) begin m_shift = 0; m_bits = 0; end
        else if (m_rise) begin
          if (m_bits == 16) begin m_shift = 0; m_bits = 0; end
          else begin m_bit = m_word[15 - m_bits]; m_bits++; end
        end
      end else if (m_acc) begin
        m_word = int'(res_data); m_flag = 1;
      end else if (m_start) begin
        m_bit = m_word[15]; m_bits = 1; m_flag = 0; m_shift = 1;
      end else if (m_warn) begin
        m_flag = 0;
      end
      if (m_acc) m_elapsed = 0;
      else if (m_elapsed < 65535) m_elapsed++;
      m_oe = !cs_n; m_pu = cs_n && cfg_pullup; m_prev = sclk;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (late_read) seen_late = 1'b1;
    if (m_live && !done) begin
      check("R2/R4/R5/R8 model dout", dout, m_shift ? m_bit : !m_flag);
      check("R11 model oe", dout_oe, m_oe);
      check("R11 model pullup", dout_pu, m_pu);
      check("R3 model ready", res_ready, !m_shift);
      check("R10 model late", late_read, m_late);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic offer(input logic [15:0] w);
    res_data = w; res_valid = 1'b1; tick(1); res_valid = 1'b0;
  endtask

  task automatic clock_bit(input int hold, output logic b);
    sclk = 1'b1; tick(1); b = dout; tick(hold - 1);
    sclk = 1'b0; tick(hold);
  endtask

  task automatic read_word(input int hold, output logic [15:0] w);
    logic b;
    for (int i = 15; i >= 0; i--) begin
      clock_bit(hold, b);
      w[i] = b;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic b;
    tick(3);
    // R1 reset values
    check("R1 oe", dout_oe, 0); check("R1 pu", dout_pu, 1);
    check("R1 dout", dout, 1);  check("R1 ready", res_ready, 1);
    check("R1 late", late_read, 0);
    rst = 1'b0; tick(1);
    check("R1 dout after reset", dout, 1);
    // R11 pull-up control
    cfg_pullup = 1'b0; tick(1);
    check("R11 pullup off", dout_pu, 0);
    cfg_pullup = 1'b1; tick(1);
    check("R11 pullup on", dout_pu, 1);
    // R2 capture
    offer(16'hA5C3);
    check("R2 flag low", dout, 0);
    // R12 rise while deselected is ignored
    clock_bit(2, b);
    check("R12 deselected rise", dout, 0);
    check("R12 ready kept", res_ready, 1);
    cs_n = 1'b0; tick(2);
    check("R11 oe on", dout_oe, 1);
    // R4 shift MSB first, R3 drop during read
    for (int i = 15; i >= 0; i--) begin
      clock_bit(3, b);
      got[i] = b;
      if (i == 10) begin
        check("R3 ready low while reading", res_ready, 0);
        offer(16'h1234);
      end
    end
    check("R4 word A5C3", got, 16'hA5C3);
    clock_bit(3, b);
    check("R5 dout high after 16 bits", dout, 1);
    check("R5 ready back", res_ready, 1);
    tick(20);
    check("R6 no second flag", dout, 1);
    check("R3 dropped beat set no flag", dout, 1);
    clock_bit(2, b);
    check("R12 rise without flag", dout, 1);
    // R9 single-shot keeps flag
    offer(16'h0F0F);
    tick(1500);
    check("R9 flag held", dout, 0);
    read_word(2, got);
    check("R9 word", got, 16'h0F0F);
    clock_bit(2, b);
    // R8 continuous unread drop
    cont_mode = 1'b1;
    offer(16'h7E81);
    tick(PER - LEAD - 1);
    check("R8 still low before drop", dout, 0);
    tick(1);
    check("R8 high at drop point", dout, 1);
    tick(100);
    // R7 abort by deselect
    offer(16'hC001);
    for (int i = 0; i < 3; i++) clock_bit(2, b);
    check("R7 reading", res_ready, 0);
    cs_n = 1'b1; tick(1);
    check("R7 ready after abort", res_ready, 1);
    cs_n = 1'b0; tick(2);
    check("R7 flag stays clear", dout, 1);
    tick(400);
    // R10 late read
    seen_late = 1'b0;
    offer(16'h5555);
    tick(5);
    read_word(15, got);
    clock_bit(2, b);
    check("R10 late pulse seen", seen_late, 1);
    check("R10 word still intact", got, 16'h5555);
    tick(5);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule